// File: doc/BRIEF.md
# Suspend wake-up clock sequencer

This block brings a peripheral's clock tree out of a fully stopped low-power state and back to normal operation. It is woken by either of two events: a resume condition seen on the serial bus, or a cable attach seen as bus power appearing. The wake event is accepted only while every clock is off. Accepting it latches a wake flag, which pulls the active-low interrupt low. The sequencer then turns the clock tree on in a fixed order. The oscillator buffer comes first. After a programmable stabilisation wait, the reference clock and PLL are enabled together. After a minimum lock wait of 8.3 µs, counted on the always-on timing clock, the internal system clock is enabled last.

The mode input selects how the steps advance. In automatic mode the hardware runs every step by itself. In manual mode each step waits for a software command, with one exception: a bus resume turns the oscillator buffer on in hardware, because the bus gives only a short window before it expects a reply. Commands that arrive out of order are ignored and set a sticky sequence-error flag. A deadline counter flags a timeout if the system clock is not running within 3 ms of the wake event. A stop command issued while running removes the enables in reverse order, one per cycle.

States: STOP (all clocks off), OSC_REQ (manual attach, waiting for the oscillator command), OSC_WAIT (oscillator stabilising), PLL_REQ (manual, waiting for the PLL command), LOCK_WAIT (PLL locking), SYS_REQ (manual, waiting for the system-clock command), RUN (normal operation), OFF_SYS and OFF_PLL (shutdown steps). Transitions:
- STOP→OSC_WAIT on a resume, or on an attach in automatic mode.
- STOP→OSC_REQ on an attach in manual mode.
- OSC_REQ→OSC_WAIT on the oscillator command.
- OSC_WAIT→LOCK_WAIT (automatic) or →PLL_REQ (manual) when the stabilisation wait expires.
- PLL_REQ→LOCK_WAIT on the PLL command.
- LOCK_WAIT→RUN (automatic) or →SYS_REQ (manual) when the lock wait expires.
- SYS_REQ→RUN on the system-clock command.
- RUN→OFF_SYS on the stop command.
- OFF_SYS→OFF_PLL→STOP unconditionally.

Top module: `wake_clk_seq`

## Requirements
- R1: A `bus_resume` or `vbus_attach` pulse seen while in STOP starts a wake and sets its own flag: `wake_flags[0]` for resume, `wake_flags[1]` for attach. Either flag drives `irq_n` low on the next cycle. Wake pulses seen in any other state change nothing.
- R2: In manual mode (`auto_mode`=0), a resume sets `osc_en` on the clock edge that samples it. After an attach, `osc_en` stays low until command code 1 (oscillator on) is sampled.
- R3: Once `osc_en` rises, it stays on alone for max(`osc_wait`,1) cycles. Only after that does the PLL step follow: automatically in automatic mode, or through acceptance of the PLL command in manual mode.
- R4: `ref_en` and `pll_en` always rise and fall on the same edge.
- R5: `sys_en` rises no sooner than LOCK_CYC = ceil(8.3e-6 × CLK_HZ) cycles after `pll_en` rises.
- R6: In automatic mode, the whole order runs with no commands. `sys_en` rises exactly max(`osc_wait`,1)+LOCK_CYC cycles after the wake edge.
- R7: In manual mode, the PLL pair changes only on command code 2 in PLL_REQ, and `sys_en` only on command code 3 in SYS_REQ.
- R8: A step command (codes 1, 2, 3) outside its own request state is ignored and sets the sticky `seq_err`. Command code 6 clears `seq_err` and `timeout`; a new error in the same cycle wins.
- R9: `timeout` is set if `sys_en` has not risen within DEADLINE_CYC = CLK_HZ × 3 / 1000 cycles of the wake edge. It stays set until cleared.
- R10: `irq_n` stays low until command code 5 clears both wake flags.
- R11: Command code 4 in RUN drops `sys_en`, then `ref_en`/`pll_en`, then `osc_en`, on three consecutive edges. In any other state it is ignored.
- R12: After reset, every enable is 0, `irq_n` is 1, and the flags, `seq_err` and `timeout` are 0.
- R13: A resume and an attach in the same cycle set both flags, and sequencing follows the resume path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on timing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_mode | input | 1 | 1 = hardware runs all steps; latched when a wake is accepted |
| bus_resume | input | 1 | Bus resume condition, one-cycle pulse |
| vbus_attach | input | 1 | Cable attach (bus power seen), one-cycle pulse |
| osc_wait | input | OSC_W | Oscillator stabilisation wait, in cycles |
| cmd_op | input | 3 | Software command: 0 none, 1 osc, 2 PLL, 3 sys, 4 stop, 5 ack wake, 6 ack error |
| osc_en | output | 1 | Oscillator buffer enable |
| ref_en | output | 1 | Reference clock enable |
| pll_en | output | 1 | PLL enable |
| sys_en | output | 1 | Internal system clock enable |
| irq_n | output | 1 | Active-low wake interrupt |
| wake_flags | output | 2 | Bit 0 resume seen, bit 1 attach seen |
| seq_err | output | 1 | Sticky out-of-order command flag |
| timeout | output | 1 | Sticky recovery deadline miss |

## Verification
The assertions assume that all inputs are synchronous to `clk`, that at most one command code is present per cycle, and that `auto_mode` does not matter once a wake has been accepted, since it is latched then. The bench drives every input on the falling edge, presents wake events and commands as one-cycle pulses, and holds `osc_wait` constant through each sequence. A behavioural model in the bench follows phase, remaining wait, flags and deadline age with plain integers. It is compared with the outputs on every cycle. Directed cycle counts are added for the automatic timing, the manual hold points, the shutdown order and the deadline miss.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

    typedef enum logic [3:0] {
        S_STOP      = 4'd0,
        S_OSC_REQ   = 4'd1,
        S_OSC_WAIT  = 4'd2,
        S_PLL_REQ   = 4'd3,
        S_LOCK_WAIT = 4'd4,
        S_SYS_REQ   = 4'd5,
        S_RUN       = 4'd6,
        S_OFF_SYS   = 4'd7,
        S_OFF_PLL   = 4'd8
    } wcs_state_e;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_OSC      = 3'd1,
        OP_PLL      = 3'd2,
        OP_SYS      = 3'd3,
        OP_STOP     = 3'd4,
        OP_ACK_WAKE = 3'd5,
        OP_ACK_ERR  = 3'd6,
        OP_RSVD     = 3'd7
    } wcs_op_e;

    typedef struct packed {
        logic osc;
        logic refc;
        logic pll;
        logic sys;
    } wcs_en_t;

endpackage

// File: rtl/wcs_timer.sv
// Down-counter shared by the stabilisation wait and the lock wait.
module wcs_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Expires in the last cycle of the window; a zero load gives one cycle.
    assign expired = (cnt_q <= TW'(1));

endmodule

// File: rtl/wcs_deadline.sv
// Recovery budget counter: armed at wake, disarmed when the system clock runs.
module wcs_deadline #(
    parameter int DL = 36000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic done,
    input  logic clr,
    output logic timeout
);

    localparam int DW = (DL < 2) ? 1 : $clog2(DL + 1);

    logic [DW-1:0] age_q;
    logic          armed_q;
    logic          hit;

    assign hit = armed_q && !start && !done && (age_q == DW'(DL - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q   <= '0;
            armed_q <= 1'b0;
        end else if (start) begin
            age_q   <= '0;
            armed_q <= 1'b1;
        end else if (armed_q) begin
            if (done || hit) begin
                armed_q <= 1'b0;
            end else begin
                age_q <= age_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout <= 1'b0;
        end else begin
            timeout <= (timeout & ~clr) | hit;
        end
    end

    AST_TIMEOUT_NOT_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> !$past(done)); // R9

    AST_TIMEOUT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !timeout); // R8

endmodule

// File: rtl/wcs_status.sv
// Wake flags, interrupt and sticky sequence-error bit.
module wcs_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_res,
    input  logic       set_att,
    input  logic       ack_wake,
    input  logic       set_err,
    input  logic       ack_err,
    output logic [1:0] wake_flags,
    output logic       seq_err,
    output logic       irq_n
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_flags <= 2'b00;
            seq_err    <= 1'b0;
        end else begin
            wake_flags <= (wake_flags & {2{~ack_wake}}) | {set_att, set_res};
            seq_err    <= (seq_err & ~ack_err) | set_err;
        end
    end

    assign irq_n = ~(|wake_flags);

    AST_WAKE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (set_res || set_att) |=> !irq_n); // R1

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !ack_wake) |=> !irq_n); // R10

    AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wake && !set_res && !set_att) |=> irq_n); // R10

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_err && !ack_err) |=> seq_err); // R8

endmodule

// File: rtl/wcs_fsm.sv
// Wake sequencing state machine: state register, next state, Moore enables.
module wcs_fsm
    import wcs_pkg::*;
#(
    parameter int OSC_W    = 16,
    parameter int TW       = 16,
    parameter int LOCK_CYC = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_mode,
    input  logic             bus_resume,
    input  logic             vbus_attach,
    input  logic [OSC_W-1:0] osc_wait,
    input  logic [2:0]       cmd_op,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [TW-1:0]    tmr_val,
    output logic             acc_res,
    output logic             acc_att,
    output logic             step_bad,
    output logic             running,
    output wcs_en_t          en
);

    localparam int LW = $clog2(LOCK_CYC + 1);

    wcs_state_e st_q, st_n;
    wcs_op_e    op;
    logic       auto_q;
    logic       wake_ok;

    assign op      = wcs_op_e'(cmd_op);
    assign wake_ok = (st_q == S_STOP) && (bus_resume || vbus_attach);
    assign acc_res = wake_ok && bus_resume;
    assign acc_att = wake_ok && vbus_attach;
    assign running = (st_q == S_RUN);

    // Step commands are legal only in their own request state.
    always_comb begin
        step_bad = 1'b0;
        unique case (op)
            OP_OSC:  step_bad = (st_q != S_OSC_REQ);
            OP_PLL:  step_bad = (st_q != S_PLL_REQ);
            OP_SYS:  step_bad = (st_q != S_SYS_REQ);
            default: step_bad = 1'b0;
        endcase
    end

    // State register and latched mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_STOP;
            auto_q <= 1'b0;
        end else begin
            st_q <= st_n;
            if (wake_ok) begin
                auto_q <= auto_mode;
            end
        end
    end

    // Next state and timer loads.
    always_comb begin
        st_n     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st_q)
            S_STOP: begin
                if (bus_resume || (vbus_attach && auto_mode)) begin
                    st_n     = S_OSC_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(osc_wait);
                end else if (vbus_attach) begin
                    st_n = S_OSC_REQ;
                end
            end
            S_OSC_REQ: begin
                if (op == OP_OSC) begin
                    st_n     = S_OSC_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(osc_wait);
                end
            end
            S_OSC_WAIT: begin
                if (tmr_expired) begin
                    if (auto_q) begin
                        st_n     = S_LOCK_WAIT;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(LOCK_CYC);
                    end else begin
                        st_n = S_PLL_REQ;
                    end
                end
            end
            S_PLL_REQ: begin
                if (op == OP_PLL) begin
                    st_n     = S_LOCK_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(LOCK_CYC);
                end
            end
            S_LOCK_WAIT: begin
                if (tmr_expired) begin
                    st_n = auto_q ? S_RUN : S_SYS_REQ;
                end
            end
            S_SYS_REQ: begin
                if (op == OP_SYS) begin
                    st_n = S_RUN;
                end
            end
            S_RUN: begin
                if (op == OP_STOP) begin
                    st_n = S_OFF_SYS;
                end
            end
            S_OFF_SYS: st_n = S_OFF_PLL;
            S_OFF_PLL: st_n = S_STOP;
            default:   st_n = S_STOP;
        endcase
    end

    // Moore enable decode.
    always_comb begin
        en = '0;
        unique case (st_q)
            S_STOP, S_OSC_REQ: en = '0;
            S_OSC_WAIT, S_PLL_REQ, S_OFF_PLL: begin
                en.osc = 1'b1;
            end
            S_LOCK_WAIT, S_SYS_REQ, S_OFF_SYS: begin
                en.osc  = 1'b1;
                en.refc = 1'b1;
                en.pll  = 1'b1;
            end
            S_RUN: begin
                en.osc  = 1'b1;
                en.refc = 1'b1;
                en.pll  = 1'b1;
                en.sys  = 1'b1;
            end
            default: en = '0;
        endcase
    end

    // Lock-age helper for the minimum-lock check.
    logic [LW-1:0] lock_age;
    always_ff @(posedge clk) begin
        if (!rst_n || !en.pll) begin
            lock_age <= '0;
        end else if (lock_age < LW'(LOCK_CYC)) begin
            lock_age <= lock_age + 1'b1;
        end
    end

    AST_RESUME_HW_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_STOP && bus_resume) |=> en.osc); // R2

    AST_ATTACH_WAITS_SW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_STOP && vbus_attach && !bus_resume && !auto_mode) |=> !en.osc); // R2

    AST_PLL_AFTER_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en.pll) |-> ($past(en.osc) && $rose(en.refc))); // R4

    AST_LOCK_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en.sys) |-> (lock_age >= LW'(LOCK_CYC))); // R5

    AST_MANUAL_PLL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_q && st_q == S_PLL_REQ && op != OP_PLL) |=> !en.pll); // R7

    AST_MANUAL_SYS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_q && st_q == S_SYS_REQ && op != OP_SYS) |=> !en.sys); // R7

    AST_STOP_SYS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en.sys) |-> (en.pll && en.osc)); // R11

    AST_STOP_PLL_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en.pll) |-> (en.osc && !en.sys)); // R11

    AST_STOP_OSC_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en.osc) |-> (!en.pll && !en.sys)); // R11

    AST_WAKE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != S_STOP && st_q != S_OFF_PLL) |=> (st_q != S_STOP)); // R1

endmodule

// File: rtl/wake_clk_seq.sv
module wake_clk_seq
    import wcs_pkg::*;
#(
    parameter int CLK_HZ = 12_000_000,
    parameter int OSC_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_mode,
    input  logic             bus_resume,
    input  logic             vbus_attach,
    input  logic [OSC_W-1:0] osc_wait,
    input  logic [2:0]       cmd_op,
    output logic             osc_en,
    output logic             ref_en,
    output logic             pll_en,
    output logic             sys_en,
    output logic             irq_n,
    output logic [1:0]       wake_flags,
    output logic             seq_err,
    output logic             timeout
);

    localparam longint LOCK_L       = (longint'(CLK_HZ) * 83 + 64'd9_999_999) / 64'd10_000_000;
    localparam int     LOCK_CYC     = (LOCK_L < 1) ? 1 : int'(LOCK_L);
    localparam longint DL_L         = (longint'(CLK_HZ) * 3) / 64'd1000;
    localparam int     DEADLINE_CYC = (DL_L < 2) ? 2 : int'(DL_L);
    localparam int     LW           = $clog2(LOCK_CYC + 1);
    localparam int     TW           = (OSC_W > LW) ? OSC_W : LW;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_expired;
    logic          acc_res;
    logic          acc_att;
    logic          step_bad;
    logic          running;
    wcs_en_t       en;

    wcs_fsm #(
        .OSC_W    (OSC_W),
        .TW       (TW),
        .LOCK_CYC (LOCK_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .auto_mode   (auto_mode),
        .bus_resume  (bus_resume),
        .vbus_attach (vbus_attach),
        .osc_wait    (osc_wait),
        .cmd_op      (cmd_op),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .acc_res     (acc_res),
        .acc_att     (acc_att),
        .step_bad    (step_bad),
        .running     (running),
        .en          (en)
    );

    wcs_timer #(
        .TW (TW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    wcs_deadline #(
        .DL (DEADLINE_CYC)
    ) u_deadline (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (acc_res | acc_att),
        .done    (running),
        .clr     (cmd_op == OP_ACK_ERR),
        .timeout (timeout)
    );

    wcs_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_res    (acc_res),
        .set_att    (acc_att),
        .ack_wake   (cmd_op == OP_ACK_WAKE),
        .set_err    (step_bad),
        .ack_err    (cmd_op == OP_ACK_ERR),
        .wake_flags (wake_flags),
        .seq_err    (seq_err),
        .irq_n      (irq_n)
    );

    assign osc_en = en.osc;
    assign ref_en = en.refc;
    assign pll_en = en.pll;
    assign sys_en = en.sys;

    AST_BAD_STEP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        step_bad |=> seq_err); // R8

    AST_BOTH_WAKE_RESUME_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_res && acc_att) |=> (osc_en && wake_flags == 2'b11)); // R13

endmodule

// File: tb/wake_clk_seq_test.sv
`timescale 1ns/1ps
module wake_clk_seq_test;

    localparam int CLK_HZ = 2_000_000;
    localparam int OSC_W  = 8;
    localparam int LOCK   = 17;    // ceil(8.3us * 2 MHz)
    localparam int DL     = 6000;  // 3 ms at 2 MHz

    localparam logic [2:0] C_NONE = 3'd0, C_OSC = 3'd1, C_PLL = 3'd2, C_SYS = 3'd3,
                           C_STOP = 3'd4, C_ACKW = 3'd5, C_ACKE = 3'd6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic auto_mode = 1'b0;
    logic bus_resume = 1'b0;
    logic vbus_attach = 1'b0;
    logic [OSC_W-1:0] osc_wait = '0;
    logic [2:0] cmd_op = 3'd0;
    logic osc_en, ref_en, pll_en, sys_en, irq_n, seq_err, timeout;
    logic [1:0] wake_flags;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit cmp_on   = 0;

    always #2.5 clk = ~clk;

    wake_clk_seq #(.CLK_HZ(CLK_HZ), .OSC_W(OSC_W)) uut (
        .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .bus_resume(bus_resume),
        .vbus_attach(vbus_attach), .osc_wait(osc_wait), .cmd_op(cmd_op),
        .osc_en(osc_en), .ref_en(ref_en), .pll_en(pll_en), .sys_en(sys_en),
        .irq_n(irq_n), .wake_flags(wake_flags), .seq_err(seq_err), .timeout(timeout)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Behavioural reference: 0 stop,1 osc req,2 osc wait,3 pll req,4 lock wait,
    // 5 sys req,6 run,7 sys off,8 pll off.
    int ph = 0, rem = 0, el = 0;
    bit man = 0, armed = 0, m_err = 0, m_tmo = 0;
    bit [1:0] m_flags = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            ph = 0; rem = 0; el = 0; man = 0; armed = 0;
            m_err = 0; m_tmo = 0; m_flags = 0;
        end else begin
            if (cmd_op == C_ACKE) begin m_err = 0; m_tmo = 0; end
            if (cmd_op == C_ACKW) m_flags = 0;
            if (armed) begin
                if (ph == 6) armed = 0;
                else begin
                    el++;
                    if (el == DL) begin m_tmo = 1; armed = 0; end
                end
            end
            if ((cmd_op == C_OSC && ph != 1) || (cmd_op == C_PLL && ph != 3) ||
                (cmd_op == C_SYS && ph != 5)) m_err = 1;
            case (ph)
                0: if (bus_resume || vbus_attach) begin
                       man = !auto_mode;
                       m_flags = m_flags | {vbus_attach, bus_resume};
                       armed = 1; el = 0;
                       if (bus_resume || !man) begin
                           ph = 2; rem = (osc_wait == 0) ? 1 : int'(osc_wait);
                       end else ph = 1;
                   end
                1: if (cmd_op == C_OSC) begin ph = 2; rem = (osc_wait == 0) ? 1 : int'(osc_wait); end
                2: if (rem == 1) begin
                       if (man) ph = 3; else begin ph = 4; rem = LOCK; end
                   end else rem--;
                3: if (cmd_op == C_PLL) begin ph = 4; rem = LOCK; end
                4: if (rem == 1) ph = man ? 5 : 6; else rem--;
                5: if (cmd_op == C_SYS) ph = 6;
                6: if (cmd_op == C_STOP) ph = 7;
                7: ph = 8;
                8: ph = 0;
                default: ph = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            check("R3 osc_en model", osc_en, int'(ph >= 2));
            check("R4 ref_en model", ref_en, int'(ph >= 4 && ph <= 7));
            check("R4 pll_en model", pll_en, int'(ph >= 4 && ph <= 7));
            check("R5 sys_en model", sys_en, int'(ph == 6));
            check("R1 wake_flags model", wake_flags, m_flags);
            check("R10 irq_n model", irq_n, int'(m_flags == 0));
            check("R8 seq_err model", seq_err, m_err);
            check("R9 timeout model", timeout, m_tmo);
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog R12: actual cycle %0d expected completion before 150000", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cmd(input logic [2:0] c);
        cmd_op = c;
        @(negedge clk);
        cmd_op = C_NONE;
    endtask

    task automatic wake(input bit r, input bit a);
        bus_resume = r; vbus_attach = a;
        @(negedge clk);
        bus_resume = 0; vbus_attach = 0;
    endtask

    task automatic shutdown();
        cmd(C_STOP);
        check("R11 sys off first", sys_en, 0);
        check("R11 pll still on", pll_en, 1);
        idle(1);
        check("R11 pll off second", pll_en, 0);
        check("R11 osc still on", osc_en, 1);
        idle(1);
        check("R11 osc off last", osc_en, 0);
    endtask

    task automatic time_auto(input bit r, input int exp_cyc);
        int n = 0;
        wake(r, !r);
        while (!sys_en && n < 1000) begin @(negedge clk); n++; end
        check("R6 auto wake to sys_en cycles", n, exp_cyc);
    endtask

    initial begin
        idle(4);
        rst_n = 1;
        check("R12 reset osc_en", osc_en, 0);
        check("R12 reset pll_en", pll_en, 0);
        check("R12 reset sys_en", sys_en, 0);
        check("R12 reset irq_n", irq_n, 1);
        check("R12 reset seq_err", seq_err, 0);
        check("R12 reset timeout", timeout, 0);
        cmp_on = 1;

        // Automatic resume run.
        auto_mode = 1; osc_wait = 8'd5;
        time_auto(1, 5 + LOCK);
        check("R1 resume flag", wake_flags, 1);
        check("R1 irq low", irq_n, 0);
        check("R9 no timeout in auto run", timeout, 0);
        cmd(C_ACKW);
        check("R10 irq released on ack", irq_n, 1);
        shutdown();

        // Manual attach run with out-of-order commands.
        auto_mode = 0; osc_wait = 8'd3;
        wake(0, 1);
        idle(5);
        check("R2 attach leaves osc off", osc_en, 0);
        check("R1 attach flag", wake_flags, 2);
        cmd(C_SYS);
        check("R8 early sys sets err", seq_err, 1);
        check("R8 early sys ignored", sys_en, 0);
        cmd(C_ACKE);
        check("R8 err cleared", seq_err, 0);
        cmd(C_OSC);
        check("R2 osc on by command", osc_en, 1);
        cmd(C_PLL);
        check("R8 pll during osc wait flagged", seq_err, 1);
        check("R3 pll held during osc wait", pll_en, 0);
        cmd(C_ACKE);
        idle(5);
        check("R7 pll waits for command", pll_en, 0);
        cmd(C_PLL);
        check("R7 pll on by command", pll_en, 1);
        check("R4 ref with pll", ref_en, 1);
        cmd(C_SYS);
        check("R8 sys in lock wait flagged", seq_err, 1);
        check("R5 sys held in lock wait", sys_en, 0);
        cmd(C_ACKE);
        idle(20);
        check("R7 sys waits for command", sys_en, 0);
        cmd(C_SYS);
        check("R7 sys on by command", sys_en, 1);
        cmd(C_ACKW);
        shutdown();

        // Manual resume: oscillator in hardware; wakes and stop ignored elsewhere.
        wake(1, 0);
        check("R2 resume osc by hardware", osc_en, 1);
        idle(5);
        cmd(C_STOP);
        check("R11 stop ignored mid-sequence", osc_en, 1);
        cmd(C_PLL);
        idle(20);
        cmd(C_SYS);
        check("R7 manual resume reaches run", sys_en, 1);
        wake(0, 1);
        check("R1 attach in run ignored", wake_flags, 1);
        check("R1 run unchanged", sys_en, 1);
        cmd(C_ACKW);
        shutdown();
        cmd(C_STOP);
        check("R11 stop in stop ignored", osc_en, 0);

        // Deadline miss in manual attach.
        wake(0, 1);
        idle(DL + 5);
        check("R9 timeout after budget", timeout, 1);
        cmd(C_OSC); idle(5); cmd(C_PLL); idle(20); cmd(C_SYS);
        check("R9 timeout sticky", timeout, 1);
        cmd(C_ACKE);
        check("R8 ack clears timeout", timeout, 0);
        cmd(C_ACKW);
        shutdown();

        // Simultaneous wake, zero stabilisation wait.
        osc_wait = 8'd0;
        wake(1, 1);
        check("R13 both wake osc on", osc_en, 1);
        check("R13 both flags", wake_flags, 3);
        idle(2); cmd(C_PLL); idle(20); cmd(C_SYS);
        check("R13 reaches run", sys_en, 1);
        cmd(C_ACKW);
        shutdown();

        // Automatic attach with zero wait.
        auto_mode = 1;
        time_auto(0, 1 + LOCK);
        cmd(C_ACKW);
        shutdown();

        idle(3);
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule